// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block walks a circular chain of transmit descriptors kept in word-addressed memory. Each descriptor is four 32-bit words. Software loads a start address into the block and then issues a trigger. The block reads the descriptor at its current pointer. If the hardware-ownership flag is set, it collects the buffer pointer, the frame length and the per-frame options. It then offers them on a frame-send port and waits for that port to report completion. Next it writes the completion status and the released ownership back into memory, and it moves to the descriptor named by the next pointer.

The walk stops when the block meets a descriptor that software still owns. The block then raises a descriptor-unavailable flag and waits for another trigger, which makes it re-read the same descriptor. The current-descriptor address is always visible, so software can see how far the ring has been processed. An error response from memory raises a bus-error flag, and the block then stays parked until reset. The three status flags are sticky and are cleared by writing ones to a clear input.

Top module: `txring_fetch`

## Requirements
- R1: After reset, mem_req and snd_valid are 0, cur_desc_addr is 0 and all three sts_flags bits are 0.
- R2: A one-cycle kick while tx_en is 1 and the block is idle starts a fetch at cur_desc_addr. A kick while tx_en is 0 is ignored: there is no memory request, no send and no pointer change.
- R3: The descriptor words sit at byte offsets +0 (mode), +4 (buffer address), +8 (status and length) and +12 (next descriptor address). When mode bit 31 is 1, the block presents the buffer address on snd_buf and the low 16 bits of the status word on snd_len. It also presents mode bit 1 on snd_crc and mode bit 0 on snd_pad.
- R4: After snd_done, the block writes the status word back to +8 with bit 19 set and its other bits unchanged. It then writes the mode word back to +0 with bit 31 cleared and its other bits unchanged.
- R5: After the mode write-back, cur_desc_addr takes the next-descriptor address, and the block goes on to fetch that descriptor. The walk follows a ring that wraps back to its first entry.
- R6: A fetched mode word with bit 31 equal to 0 stops the walk. cur_desc_addr stays on that descriptor and sts_flags bit 1 (unavailable) is set. A later kick re-reads that same descriptor.
- R7: sts_flags bit 0 (completion) is set when a descriptor whose mode bit 2 is 1 completes. Completions with mode bit 2 equal to 0 leave it unchanged.
- R8: A memory transfer answered with mem_err sets sts_flags bit 2 (bus error). From then on the block makes no memory request and no send, and it ignores kicks until rst_n is asserted.
- R9: base_wr loads base_addr into cur_desc_addr only while the block is idle. A base_wr during a walk is ignored.
- R10: A memory request keeps mem_req, mem_addr, mem_we and mem_wdata unchanged until mem_ready. snd_valid stays high with a stable snd_buf until snd_done.
- R11: Each sts_flags bit stays set until a cycle in which the matching sts_clr bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Global transmit enable; gates kick |
| kick | input | 1 | Start trigger, one-cycle pulse |
| base_wr | input | 1 | Load strobe for the ring start address |
| base_addr | input | AW | Ring start address |
| cur_desc_addr | output | AW | Address of the descriptor being processed |
| sts_clr | input | 3 | Write-one-to-clear for sts_flags |
| sts_flags | output | 3 | Sticky flags: bit0 completion, bit1 unavailable, bit2 bus error |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Transfer completes in this cycle |
| mem_err | input | 1 | Error response, qualified by mem_ready |
| snd_valid | output | 1 | A frame is offered to the sender |
| snd_buf | output | AW | Frame buffer address |
| snd_len | output | 16 | Frame length in bytes |
| snd_crc | output | 1 | Append CRC request |
| snd_pad | output | 1 | Pad short frame request |
| snd_done | input | 1 | Sender finished the offered frame |

## Verification
The assertions assume that mem_rdata is valid in the cycle mem_ready is high, and that mem_err matters only in that same cycle. They also assume that snd_done comes only while snd_valid is high. The bench memory model returns data combinationally from the addressed word and uses a free-running ready pattern that stalls two cycles out of three in one sweep. Its send model raises snd_done for a single cycle, a few cycles after snd_valid rises. Within those limits, the sweeps vary the number of owned descriptors in a four-entry ring and the mode option bits, under both memory timings.

// File: rtl/txring_pkg.sv
package txring_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_MODE,
    ST_RD_BUF,
    ST_RD_LEN,
    ST_RD_NEXT,
    ST_SEND,
    ST_WR_STAT,
    ST_WR_MODE,
    ST_FAULT
  } ring_state_e;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LEN_W   = 16;
  localparam int unsigned OWN_BIT = 31;
  localparam int unsigned IRQ_BIT = 2;
  localparam int unsigned CRC_BIT = 1;
  localparam int unsigned PAD_BIT = 0;
  localparam int unsigned CPL_BIT = 19;

  localparam logic [3:0] OFS_MODE = 4'd0;
  localparam logic [3:0] OFS_BUF  = 4'd4;
  localparam logic [3:0] OFS_LEN  = 4'd8;
  localparam logic [3:0] OFS_NEXT = 4'd12;

  localparam int unsigned NUM_EV     = 3;
  localparam int unsigned EV_DONE    = 0;
  localparam int unsigned EV_UNAVAIL = 1;
  localparam int unsigned EV_BUSERR  = 2;

endpackage

// File: rtl/txring_flags.sv
module txring_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_d;
    logic flag_en;

    assign flag_en = set[i] | clr[i];
    assign flag_d  = set[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag[i] <= 1'b0;
      end else if (flag_en) begin
        flag[i] <= flag_d;
      end
    end

    // R11: a raised event is held as a flag
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flag[i]);
    // R11: without a clear the flag does not drop
    a_r11_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !clr[i]) |=> flag[i]);
  end

endmodule

// File: rtl/txring_seq.sv
module txring_seq
  import txring_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              kick,
  input  logic              base_wr,
  input  logic [AW-1:0]     base_addr,
  output logic [AW-1:0]     cur_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready,
  input  logic              mem_err,
  output logic              snd_valid,
  output logic [AW-1:0]     snd_buf,
  output logic [LEN_W-1:0]  snd_len,
  output logic              snd_crc,
  output logic              snd_pad,
  input  logic              snd_done,
  output logic [NUM_EV-1:0] ev
);

  localparam logic [WORD_W-1:0] OWN_MASK = WORD_W'(1) << OWN_BIT;
  localparam logic [WORD_W-1:0] CPL_MASK = WORD_W'(1) << CPL_BIT;

  ring_state_e       state_q, state_d;
  logic [AW-1:0]     cur_q, cur_d;
  logic [AW-1:0]     buf_q, buf_d;
  logic [AW-1:0]     nxt_q, nxt_d;
  logic [WORD_W-1:0] mode_q, mode_d;
  logic [WORD_W-1:0] len_q, len_d;
  logic [3:0]        ofs;
  logic              xfer;
  logic              fault;

  assign xfer  = mem_req & mem_ready;
  assign fault = xfer & mem_err;

  always_comb begin
    state_d   = state_q;
    cur_d     = cur_q;
    buf_d     = buf_q;
    nxt_d     = nxt_q;
    mode_d    = mode_q;
    len_d     = len_q;
    ofs       = OFS_MODE;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    snd_valid = 1'b0;
    ev        = '0;
    if (fault) begin
      ev[EV_BUSERR] = 1'b1;
    end
    case (state_q)
      ST_IDLE: begin
        if (base_wr) cur_d = base_addr;
        if (kick && tx_en) state_d = ST_RD_MODE;
      end
      ST_RD_MODE: begin
        mem_req = 1'b1;
        ofs     = OFS_MODE;
        if (fault) begin
          state_d = ST_FAULT;
        end else if (xfer && !mem_rdata[OWN_BIT]) begin
          state_d         = ST_IDLE;
          ev[EV_UNAVAIL]  = 1'b1;
        end else if (xfer) begin
          mode_d  = mem_rdata;
          state_d = ST_RD_BUF;
        end
      end
      ST_RD_BUF: begin
        mem_req = 1'b1;
        ofs     = OFS_BUF;
        if (fault) begin
          state_d = ST_FAULT;
        end else if (xfer) begin
          buf_d   = mem_rdata[AW-1:0];
          state_d = ST_RD_LEN;
        end
      end
      ST_RD_LEN: begin
        mem_req = 1'b1;
        ofs     = OFS_LEN;
        if (fault) begin
          state_d = ST_FAULT;
        end else if (xfer) begin
          len_d   = mem_rdata;
          state_d = ST_RD_NEXT;
        end
      end
      ST_RD_NEXT: begin
        mem_req = 1'b1;
        ofs     = OFS_NEXT;
        if (fault) begin
          state_d = ST_FAULT;
        end else if (xfer) begin
          nxt_d   = mem_rdata[AW-1:0];
          state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        snd_valid = 1'b1;
        if (snd_done) state_d = ST_WR_STAT;
      end
      ST_WR_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        ofs       = OFS_LEN;
        mem_wdata = len_q | CPL_MASK;
        if (fault) state_d = ST_FAULT;
        else if (xfer) state_d = ST_WR_MODE;
      end
      ST_WR_MODE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        ofs       = OFS_MODE;
        mem_wdata = mode_q & ~OWN_MASK;
        if (fault) begin
          state_d = ST_FAULT;
        end else if (xfer) begin
          cur_d        = nxt_q;
          ev[EV_DONE]  = mode_q[IRQ_BIT];
          state_d      = ST_RD_MODE;
        end
      end
      ST_FAULT: state_d = ST_FAULT;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      buf_q   <= '0;
      nxt_q   <= '0;
      mode_q  <= '0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      buf_q   <= buf_d;
      nxt_q   <= nxt_d;
      mode_q  <= mode_d;
      len_q   <= len_d;
    end
  end

  assign mem_addr = cur_q + AW'(ofs);
  assign cur_addr = cur_q;
  assign snd_buf  = buf_q;
  assign snd_len  = len_q[LEN_W-1:0];
  assign snd_crc  = mode_q[CRC_BIT];
  assign snd_pad  = mode_q[PAD_BIT];

  // R10: memory request held steady until accepted
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  // R10: frame offer held until the sender finishes
  a_r10_snd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_valid && !snd_done) |=> (snd_valid && $stable(snd_buf) && $stable(snd_len)));
  // R4: ownership is always handed back on a write to the mode word
  a_r4_own_release: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr == cur_addr) |-> !mem_wdata[OWN_BIT]);
  // R6: a software-owned mode word stops the walk at the same pointer
  a_r6_unavail_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !mem_err && !mem_we && mem_addr == cur_addr && !mem_rdata[OWN_BIT])
      |=> (!mem_req && !snd_valid && $stable(cur_addr)));
  // R8: after an error response nothing moves
  a_r8_fault_park: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!mem_req && !snd_valid) ##1 (!mem_req && !snd_valid && $stable(cur_addr)));
  // R2: with transmit disabled an idle block stays off the bus
  a_r2_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && !snd_valid && !tx_en) |=> !mem_req);
  // R10: memory and sender are never active together
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && snd_valid));

endmodule

// File: rtl/txring_fetch.sv
module txring_fetch
  import txring_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              kick,
  input  logic              base_wr,
  input  logic [AW-1:0]     base_addr,
  output logic [AW-1:0]     cur_desc_addr,
  input  logic [2:0]        sts_clr,
  output logic [2:0]        sts_flags,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ready,
  input  logic              mem_err,
  output logic              snd_valid,
  output logic [AW-1:0]     snd_buf,
  output logic [15:0]       snd_len,
  output logic              snd_crc,
  output logic              snd_pad,
  input  logic              snd_done
);

  logic [NUM_EV-1:0] ev;

  txring_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .kick      (kick),
    .base_wr   (base_wr),
    .base_addr (base_addr),
    .cur_addr  (cur_desc_addr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ready (mem_ready),
    .mem_err   (mem_err),
    .snd_valid (snd_valid),
    .snd_buf   (snd_buf),
    .snd_len   (snd_len),
    .snd_crc   (snd_crc),
    .snd_pad   (snd_pad),
    .snd_done  (snd_done),
    .ev        (ev)
  );

  txring_flags #(.N(NUM_EV)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ev),
    .clr   (sts_clr),
    .flag  (sts_flags)
  );

endmodule

// File: tb/txring_fetch_bench.sv
`timescale 1ns/1ps
module txring_fetch_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_en, kick, base_wr;
  logic [31:0] base_addr;
  logic [31:0] cur_desc_addr;
  logic [2:0]  sts_clr, sts_flags;
  logic        mem_req, mem_we, mem_ready, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        snd_valid, snd_crc, snd_pad, snd_done;
  logic [31:0] snd_buf;
  logic [15:0] snd_len;

  always #4 clk = ~clk;

  txring_fetch #(.AW(32)) u_txring_fetch (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .kick(kick),
    .base_wr(base_wr), .base_addr(base_addr), .cur_desc_addr(cur_desc_addr),
    .sts_clr(sts_clr), .sts_flags(sts_flags),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .mem_err(mem_err), .snd_valid(snd_valid), .snd_buf(snd_buf),
    .snd_len(snd_len), .snd_crc(snd_crc), .snd_pad(snd_pad), .snd_done(snd_done)
  );

  int checks = 0;
  int errors = 0;

  // memory model
  logic [31:0] mem [0:127];
  logic        bd_we;
  logic [6:0]  bd_idx;
  logic [31:0] bd_data;
  logic        stall_mode, err_en;
  logic [31:0] err_addr;
  logic [1:0]  stall_cnt;

  assign mem_rdata = mem[mem_addr[8:2]];
  assign mem_ready = stall_mode ? (stall_cnt == 2'd2) : 1'b1;
  assign mem_err   = err_en && (mem_addr == err_addr);

  always @(posedge clk) begin
    stall_cnt <= (stall_cnt == 2'd2) ? 2'd0 : stall_cnt + 2'd1;
    if (bd_we) mem[bd_idx] <= bd_data;
    else if (mem_req && mem_ready && mem_we && !mem_err) mem[mem_addr[8:2]] <= mem_wdata;
  end

  // sender model and log
  logic [31:0] log_buf [0:63];
  logic [15:0] log_len [0:63];
  logic        log_crc [0:63];
  logic        log_pad [0:63];
  int          n_sent = 0;
  int          scnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      snd_done <= 1'b0;
      scnt <= 0;
    end else if (snd_valid && snd_done) begin
      if (n_sent < 64) begin
        log_buf[n_sent] <= snd_buf;
        log_len[n_sent] <= snd_len;
        log_crc[n_sent] <= snd_crc;
        log_pad[n_sent] <= snd_pad;
      end
      n_sent <= n_sent + 1;
      snd_done <= 1'b0;
      scnt <= 0;
    end else if (snd_valid) begin
      if (scnt == 2) snd_done <= 1'b1;
      else scnt <= scnt + 1;
    end
  end

  // R10 hold monitor
  logic        p_req, p_ready, p_we, p_snd;
  logic [31:0] p_addr, p_wdata, p_buf;
  int          hold_viol = 0;
  int          req_seen = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      p_req <= 1'b0;
      p_snd <= 1'b0;
    end else begin
      if (p_req && !p_ready &&
          !(mem_req && mem_addr == p_addr && mem_we == p_we && mem_wdata == p_wdata))
        hold_viol <= hold_viol + 1;
      if (p_snd && !(snd_valid && snd_buf == p_buf))
        hold_viol <= hold_viol + 1;
      if (mem_req) req_seen <= req_seen + 1;
      p_req   <= mem_req;
      p_ready <= mem_ready;
      p_we    <= mem_we;
      p_addr  <= mem_addr;
      p_wdata <= mem_wdata;
      p_snd   <= snd_valid && !snd_done;
      p_buf   <= snd_buf;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_word(input logic [31:0] addr, input logic [31:0] data);
    bd_we = 1'b1; bd_idx = addr[8:2]; bd_data = data;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic set_desc(input int i, input logic own, input logic [2:0] opt, input logic [15:0] len);
    logic [31:0] a;
    a = 32'h100 + 32'(16 * i);
    wr_word(a,      {own, 28'd0, opt});
    wr_word(a + 4,  32'h1000 + 32'(256 * i));
    wr_word(a + 8,  {16'd0, len});
    wr_word(a + 12, 32'h100 + 32'(16 * ((i + 1) % 4)));
  endtask

  task automatic pulse_kick();
    kick = 1'b1; @(negedge clk); kick = 1'b0;
  endtask

  task automatic load_base(input logic [31:0] a);
    base_wr = 1'b1; base_addr = a; @(negedge clk); base_wr = 1'b0;
  endtask

  task automatic clear_flags();
    sts_clr = 3'b111; @(negedge clk); sts_clr = 3'b000;
  endtask

  task automatic wait_flag(input int b, input string tag);
    int n = 0;
    while (!sts_flags[b] && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 3000, tag, 32'(n), 32'd3000);
    repeat (4) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s0, rq0;
    rst_n = 1'b0; tx_en = 1'b0; kick = 1'b0; base_wr = 1'b0; base_addr = '0;
    sts_clr = '0; bd_we = 1'b0; bd_idx = '0; bd_data = '0;
    stall_mode = 1'b0; err_en = 1'b0; err_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mem_req == 1'b0 && snd_valid == 1'b0, "R1 idle outputs", {30'd0, mem_req, snd_valid}, 32'd0);
    chk(cur_desc_addr == 32'd0, "R1 pointer", cur_desc_addr, 32'd0);
    chk(sts_flags == 3'd0, "R1 flags", 32'(sts_flags), 32'd0);
    tx_en = 1'b1;

    // sweep over memory timing and number of owned descriptors
    for (int st = 0; st < 2; st++) begin
      stall_mode = st[0];
      for (int k = 1; k <= 4; k++) begin
        logic anyirq;
        anyirq = 1'b0;
        for (int i = 0; i < 4; i++)
          set_desc(i, i < k, 3'((i + k + st) % 8), 16'(60 + 17 * i + k));
        clear_flags();
        chk(sts_flags == 3'd0, "R11 clear", 32'(sts_flags), 32'd0);
        load_base(32'h100);
        chk(cur_desc_addr == 32'h100, "R9 idle load", cur_desc_addr, 32'h100);
        s0 = n_sent;
        pulse_kick();
        wait_flag(1, "R6 unavailable flag");
        chk(n_sent - s0 == k, "R3 send count", 32'(n_sent - s0), 32'(k));
        for (int j = 0; j < k; j++) begin
          logic [2:0] opt;
          logic [15:0] ln;
          opt = 3'((j + k + st) % 8);
          ln  = 16'(60 + 17 * j + k);
          if (opt[2]) anyirq = 1'b1;
          chk(log_buf[s0 + j] == 32'h1000 + 32'(256 * j), "R3 buffer", log_buf[s0 + j], 32'h1000 + 32'(256 * j));
          chk(log_len[s0 + j] == ln, "R3 length", 32'(log_len[s0 + j]), 32'(ln));
          chk(log_crc[s0 + j] == opt[1] && log_pad[s0 + j] == opt[0], "R3 options",
              {30'd0, log_crc[s0 + j], log_pad[s0 + j]}, {30'd0, opt[1], opt[0]});
          chk(mem[7'(64 + 4 * j)] == {29'd0, opt}, "R4 mode released", mem[7'(64 + 4 * j)], {29'd0, opt});
          chk(mem[7'(66 + 4 * j)] == ({16'd0, ln} | 32'h0008_0000), "R4 status", mem[7'(66 + 4 * j)],
              {16'd0, ln} | 32'h0008_0000);
        end
        chk(cur_desc_addr == 32'h100 + 32'(16 * (k % 4)), "R5 R6 pointer", cur_desc_addr, 32'h100 + 32'(16 * (k % 4)));
        chk(sts_flags[0] == anyirq, "R7 completion flag", 32'(sts_flags[0]), 32'(anyirq));
      end
    end

    // base write during a walk is ignored (R9)
    stall_mode = 1'b1;
    for (int i = 0; i < 4; i++) set_desc(i, 1'b1, 3'd3, 16'(100 + i));
    clear_flags();
    load_base(32'h100);
    s0 = n_sent;
    pulse_kick();
    while (!snd_valid) @(negedge clk);
    load_base(32'h300);
    wait_flag(1, "R9 walk end");
    chk(cur_desc_addr == 32'h100, "R9 busy load ignored", cur_desc_addr, 32'h100);
    chk(n_sent - s0 == 4, "R5 full ring wrap", 32'(n_sent - s0), 32'd4);
    chk(sts_flags[0] == 1'b0, "R7 no completion request", 32'(sts_flags[0]), 32'd0);

    // kick with transmit disabled (R2)
    set_desc(0, 1'b1, 3'd4, 16'd64);
    clear_flags();
    tx_en = 1'b0;
    s0 = n_sent;
    rq0 = req_seen;
    pulse_kick();
    repeat (40) @(negedge clk);
    chk(req_seen == rq0, "R2 no memory access", 32'(req_seen - rq0), 32'd0);
    chk(n_sent == s0 && cur_desc_addr == 32'h100, "R2 no send", cur_desc_addr, 32'h100);
    // re-trigger resumes at the same descriptor (R6, R2)
    tx_en = 1'b1;
    pulse_kick();
    wait_flag(1, "R6 resume park");
    chk(n_sent - s0 == 1 && log_buf[s0] == 32'h1000, "R6 resume at pointer", log_buf[s0], 32'h1000);
    chk(cur_desc_addr == 32'h110, "R6 next park", cur_desc_addr, 32'h110);
    chk(sts_flags[0] == 1'b1, "R7 completion set", 32'(sts_flags[0]), 32'd1);

    // bus error (R8)
    set_desc(1, 1'b1, 3'd0, 16'd80);
    clear_flags();
    err_en = 1'b1; err_addr = 32'h118;
    s0 = n_sent;
    pulse_kick();
    wait_flag(2, "R8 bus error flag");
    chk(n_sent == s0, "R8 no send", 32'(n_sent - s0), 32'd0);
    err_en = 1'b0;
    rq0 = req_seen;
    pulse_kick();
    repeat (30) @(negedge clk);
    chk(req_seen == rq0 && !snd_valid, "R8 parked", 32'(req_seen - rq0), 32'd0);
    chk(cur_desc_addr == 32'h110, "R8 pointer held", cur_desc_addr, 32'h110);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sts_flags == 3'd0 && cur_desc_addr == 32'd0, "R1 R8 after reset", {29'd0, sts_flags}, 32'd0);

    chk(hold_viol == 0, "R10 handshake hold", 32'(hold_viol), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule